// File: doc/BRIEF.md
# PHY Control Register Bank with Per-Bit Write Enables

This block is a small register bank that sits between a simple 32-bit register bus and a PHY's sideband controls. Every writable register takes a self-masking write: the upper half of the written word is a per-bit enable for the lower half. Software can therefore change a single field without reading the register first. Bits whose enable is clear keep their value.

The bank has three slots. The configuration slot drives the PHY's test/config port: a write strobe, a 6-bit address and a 4-bit data nibble. When the port is used for a read, the slot also supplies a wider 10-bit read address. The lane slot drives one idle-force control per lane. The status slot is read-only and returns the PHY status word combinationally. It also splits out the PLL-locked and PLL-output-pending flags as separate pins.

Bus accesses complete in a single cycle. The port is always ready and never applies back-pressure: a write is accepted on every clock edge where `bus_sel` and `bus_we` are both high. Read data is a combinational function of the address and the current state.

Top module: `phy_ctl_regs`

## Requirements
- R1: A write to a writable slot updates stored bit x (0..15) only when bit x+16 of the written word is 1; every other stored bit keeps its value.
- R2: In the configuration slot (word index 0), `cfg_wstrobe` is stored bit 0, `cfg_addr` is stored bits [6:1] and `cfg_wdata` is stored bits [10:7].
- R3: `cfg_rd_addr` is stored bits [10:1] of the configuration slot, i.e. the 10-bit read address overlapping the address and data fields.
- R4: In the lane slot (word index 1), `lane_idle[i]` is stored bit 3+i for lanes 0..3; a 1 forces that lane idle.
- R5: Reading the status slot (word index 2) returns `phy_status` in the same cycle; writes to it change no register or output.
- R6: `pll_locked` equals `phy_status` bit 9 and `pll_pending` equals `phy_status` bit 10.
- R7: Reading a writable slot returns its 16 stored bits in [15:0] with [31:16] read as zero.
- R8: Reset clears every stored bit, so all configuration and lane outputs are 0.
- R9: Word index 3 is unmapped: it reads as zero and writes to it are ignored; with `bus_sel` low, `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access select |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 2 | Word index of the slot |
| bus_wdata | input | 32 | Write word: [31:16] bit enables, [15:0] values |
| bus_rdata | output | 32 | Read word, combinational |
| phy_status | input | 32 | Status word from the PHY |
| cfg_wdata | output | 4 | Config port write data |
| cfg_addr | output | 6 | Config port address |
| cfg_wstrobe | output | 1 | Config port write strobe |
| cfg_rd_addr | output | 10 | Config port read address |
| lane_idle | output | 4 | Per-lane idle force |
| pll_locked | output | 1 | PLL lock flag |
| pll_pending | output | 1 | PLL output pending flag |

## Verification
The assertions assume that `bus_addr`, `bus_we` and `bus_wdata` are stable and known while `bus_sel` is high. They also assume that `phy_status` changes only between accesses, so a read that is sampled within a cycle sees one status value. The bench follows both rules. It drives every input on the falling edge, holds it through the next rising edge, and changes `phy_status` only while `bus_sel` is low. The bench sweeps every enable/value nibble on the lane bits and a long pseudo-random series of masked configuration writes. For each write it computes the new register value arithmetically as a masked merge.

// File: rtl/phyreg_pkg.sv
package phyreg_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    SLOT_CFG  = 2'd0,
    SLOT_LANE = 2'd1,
    SLOT_STAT = 2'd2,
    SLOT_NONE = 2'd3
  } slot_e;

  localparam int CFG_STB_BIT   = 0;
  localparam int CFG_ADDR_LSB  = 1;
  localparam int CFG_ADDR_W    = 6;
  localparam int CFG_DATA_LSB  = 7;
  localparam int CFG_DATA_W    = 4;
  localparam int CFG_RADDR_W   = 10;
  localparam int LANE_IDLE_LSB = 3;
  localparam int PLL_LOCK_BIT  = 9;
  localparam int PLL_PEND_BIT  = 10;
endpackage

// File: rtl/masked_reg.sv
module masked_reg #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [2*W-1:0] wdata,
  output logic [W-1:0]   q
);
  logic [W-1:0] nxt;

  // per-bit merge: enable bit in upper half selects new value
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign nxt[i] = wdata[W+i] ? wdata[i] : q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= nxt;
  end

  // R1
  keep_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (((q ^ $past(q)) & ~$past(wdata[2*W-1:W])) == '0));

  // R1
  take_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (((q ^ $past(wdata[W-1:0])) & $past(wdata[2*W-1:W])) == '0));

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> (q == $past(q)));
endmodule

// File: rtl/phyreg_rdmux.sv
module phyreg_rdmux
  import phyreg_pkg::*;
#(
  parameter int HW = HALF_W,
  parameter int WW = WORD_W
) (
  input  logic          sel,
  input  logic [1:0]    addr,
  input  logic [HW-1:0] cfg_q,
  input  logic [HW-1:0] lane_q,
  input  logic [WW-1:0] status,
  output logic [WW-1:0] rdata
);
  localparam int PAD_W = WW - HW;

  always_comb begin
    rdata = '0;
    if (sel) begin
      unique case (slot_e'(addr))
        SLOT_CFG:  rdata = {{PAD_W{1'b0}}, cfg_q};
        SLOT_LANE: rdata = {{PAD_W{1'b0}}, lane_q};
        SLOT_STAT: rdata = status;
        SLOT_NONE: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/phy_ctl_regs.sv
module phy_ctl_regs
  import phyreg_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [WORD_W-1:0] phy_status,
  output logic [CFG_DATA_W-1:0]  cfg_wdata,
  output logic [CFG_ADDR_W-1:0]  cfg_addr,
  output logic                   cfg_wstrobe,
  output logic [CFG_RADDR_W-1:0] cfg_rd_addr,
  output logic [LANES-1:0]  lane_idle,
  output logic              pll_locked,
  output logic              pll_pending
);
  localparam int LANE_TOP = LANE_IDLE_LSB + LANES;

  logic              wr_cfg, wr_lane;
  logic [HALF_W-1:0] cfg_q, lane_q;

  assign wr_cfg  = bus_sel && bus_we && (slot_e'(bus_addr) == SLOT_CFG);
  assign wr_lane = bus_sel && bus_we && (slot_e'(bus_addr) == SLOT_LANE);

  masked_reg #(.W(HALF_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(wr_cfg), .wdata(bus_wdata), .q(cfg_q)
  );

  masked_reg #(.W(HALF_W)) u_lane (
    .clk(clk), .rst_n(rst_n), .we(wr_lane), .wdata(bus_wdata), .q(lane_q)
  );

  phyreg_rdmux u_rd (
    .sel(bus_sel), .addr(bus_addr), .cfg_q(cfg_q), .lane_q(lane_q),
    .status(phy_status), .rdata(bus_rdata)
  );

  assign cfg_wstrobe = cfg_q[CFG_STB_BIT];
  assign cfg_addr    = cfg_q[CFG_ADDR_LSB +: CFG_ADDR_W];
  assign cfg_wdata   = cfg_q[CFG_DATA_LSB +: CFG_DATA_W];
  assign cfg_rd_addr = cfg_q[CFG_ADDR_LSB +: CFG_RADDR_W];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_idle[l] = lane_q[LANE_IDLE_LSB + l];
  end

  assign pll_locked  = phy_status[PLL_LOCK_BIT];
  assign pll_pending = phy_status[PLL_PEND_BIT];

  initial begin
    if (LANE_TOP > HALF_W) $error("too many lanes for the lane slot");
  end

  // R4
  lane_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr == 2'd1) |->
      (bus_rdata[LANE_IDLE_LSB +: LANES] == lane_idle));

  // R7
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr[1] == 1'b0) |-> (bus_rdata[WORD_W-1:HALF_W] == '0));

  // R5
  stat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr == 2'd2) |-> (bus_rdata == phy_status));

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_sel || bus_addr == 2'd3) |-> (bus_rdata == '0));

  // R5
  stat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr[1]) |=>
      ($stable(cfg_rd_addr) && $stable(cfg_wstrobe) && $stable(lane_idle)));
endmodule

// File: tb/phy_ctl_regs_bench.sv
module phy_ctl_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, phy_status = '0;
  logic [3:0]  cfg_wdata, lane_idle;
  logic [5:0]  cfg_addr;
  logic        cfg_wstrobe, pll_locked, pll_pending;
  logic [9:0]  cfg_rd_addr;

  int checks = 0, errors = 0;
  logic [15:0] m_cfg = '0, m_lane = '0;
  logic [31:0] rng = 32'h1234_5678;
  bit done = 0;

  always #10 clk = ~clk;

  phy_ctl_regs u_phy_ctl_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .phy_status(phy_status), .cfg_wdata(cfg_wdata), .cfg_addr(cfg_addr),
    .cfg_wstrobe(cfg_wstrobe), .cfg_rd_addr(cfg_rd_addr),
    .lane_idle(lane_idle), .pll_locked(pll_locked), .pll_pending(pll_pending)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] merge(logic [15:0] old, logic [31:0] w);
    return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
  endfunction

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #2 d = bus_rdata;
    bus_sel = 0;
    #1;
  endtask

  task automatic check_outs(string tag);
    logic [31:0] r;
    chk({tag, " R2 strobe"}, {31'b0, cfg_wstrobe}, {31'b0, m_cfg[0]});
    chk({tag, " R2 addr"}, {26'b0, cfg_addr}, {26'b0, m_cfg[6:1]});
    chk({tag, " R2 data"}, {28'b0, cfg_wdata}, {28'b0, m_cfg[10:7]});
    chk({tag, " R3 rdaddr"}, {22'b0, cfg_rd_addr}, {22'b0, m_cfg[10:1]});
    chk({tag, " R4 idle"}, {28'b0, lane_idle}, {28'b0, m_lane[6:3]});
    rd(2'd0, r); chk({tag, " R7 cfg read"}, r, {16'b0, m_cfg});
    rd(2'd1, r); chk({tag, " R7 lane read"}, r, {16'b0, m_lane});
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    check_outs("R8 reset");
    rst_n = 1;
    @(negedge clk);

    // R4 R1: exhaustive enable/value sweep on lane bits 6:3
    for (int m = 0; m < 16; m++) begin
      for (int v = 0; v < 16; v++) begin
        logic [31:0] w;
        w = {9'b0, 4'(m), 3'b0, 9'b0, 4'(v), 3'b0};
        w[31:16] = w[31:16] | {rng[15:7], 4'b0, rng[2:0]};
        w[15:0]  = w[15:0]  | {rng[31:23], 4'b0, rng[18:16]};
        rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
        wr(2'd1, w);
        m_lane = merge(m_lane, w);
        chk("R4 R1 lane idle", {28'b0, lane_idle}, {28'b0, m_lane[6:3]});
      end
    end

    // R1 R2 R3: pseudo-random masked config writes
    for (int k = 0; k < 400; k++) begin
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      wr(2'd0, rng);
      m_cfg = merge(m_cfg, rng);
      if (k % 8 == 0) check_outs("R1 cfg");
      else chk("R3 rdaddr", {22'b0, cfg_rd_addr}, {22'b0, m_cfg[10:1]});
    end

    // R1: zero mask writes leave everything
    wr(2'd0, 32'h0000_FFFF);
    wr(2'd1, 32'h0000_FFFF);
    check_outs("R1 zero mask");

    // R5 R6: status sweep over bits 9/10 and walking bits
    for (int s = 0; s < 64; s++) begin
      logic [31:0] st;
      st = (32'h1 << (s % 32)) ^ (s[1:0] << 9) ^ {rng[31:11], 11'b0};
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      @(negedge clk);
      phy_status = st;
      rd(2'd2, r);
      chk("R5 status read", r, st);
      chk("R6 lock", {31'b0, pll_locked}, {31'b0, st[9]});
      chk("R6 pending", {31'b0, pll_pending}, {31'b0, st[10]});
    end

    // R5 R9: writes to status and unmapped slot are ignored
    wr(2'd2, 32'hFFFF_FFFF);
    check_outs("R5 stat write");
    wr(2'd3, 32'hFFFF_0000);
    wr(2'd3, 32'hFFFF_FFFF);
    check_outs("R9 unmapped write");
    rd(2'd3, r); chk("R9 unmapped read", r, 32'h0);
    #2 chk("R9 idle rdata", bus_rdata, 32'h0);

    // R8: reset mid-run clears state
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd1, 32'hFFFF_FFFF);
    m_cfg = 16'hFFFF; m_lane = 16'hFFFF;
    check_outs("R8 preload");
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    m_cfg = '0; m_lane = '0;
    check_outs("R8 reset again");
    rst_n = 1;

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule